// File: doc/BRIEF.md
# Sign-Magnitude Accumulator Adder

This block is the arithmetic core of an accumulator for sign-magnitude words. An operand is a sign bit plus a magnitude field. The accumulator holds a sign, two guard bits stacked above the magnitude, and the magnitude itself. A caller drives an operation code and an operand and raises `start` for one cycle. The accumulator is rewritten at that clock edge, and `done` is high for the following cycle. A new operation may start every cycle.

There are three groups of operations:

- **Loads.** Plain load, negated load and logical load. A logical load places the operand sign in the low guard bit.
- **Algebraic sums.** Add and subtract, plus two magnitude forms whose operand sign is forced positive or negative.
- **Logical add.** Adds the operand into the low guard bit and magnitude, with an end-around carry.

When the signs of the two terms differ, the datapath adds the ones' complement of the accumulator field, guard bits included. A carry out of the top guard bit then picks the fix-up:

- With a carry, the datapath increments the field and flips the sign.
- Without a carry, it complements the field again and keeps the sign.

A like-sign sum that carries out of the magnitude field sets a sticky overflow flag. Only `ovfClear` clears that flag.

Top module: `acc_adder_unit`

## Requirements
- R1: While `rstN` is low, the accumulator sign, guard bits and magnitude, `overflow` and `done` are all held at 0.
- R2: `done` is 1 in exactly the cycle after a cycle with `start` high, and 0 otherwise. Without `start`, the accumulator does not change.
- R3: `opCode` 0 loads the operand sign (operand bit MAG_W) and magnitude (operand bits MAG_W-1..0) and zeroes both guard bits. `opCode` 1 does the same with the sign inverted (1 means negative).
- R4: `opCode` 2 clears the sign and the high guard bit (`accGuard[1]`). It loads the operand sign into the low guard bit (`accGuard[0]`) and the magnitude unchanged.
- R5: When the accumulator sign equals the effective operand sign, the 37-bit field {guard, magnitude} becomes the sum with the operand magnitude modulo 2^(MAG_W+2), and the sign is kept. `overflow` is set if the magnitude fields alone carry out.
- R6: When the signs differ, the result depends on the operand magnitude compared with the whole accumulator field. If the operand magnitude is greater, the field becomes their difference and the sign flips. Otherwise the field becomes accumulator minus operand and the sign is kept, so equal values leave a zero with the accumulator's sign.
- R7: Each algebraic code sets the effective operand sign. `opCode` 3 (add) uses the operand sign. `opCode` 4 (subtract) inverts it. `opCode` 5 forces it positive. `opCode` 6 forces it negative.
- R8: `opCode` 7 adds {sign, magnitude} of the operand to {`accGuard[0]`, magnitude}, and adds any carry out back in at the least significant bit. It leaves the sign, `accGuard[1]` and `overflow` untouched.
- R9: `overflow` stays set until a cycle with `ovfClear` high. If a clear and a new overflow coincide, the flag ends up set. Unlike-sign, load and logical operations never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Execute `opCode` on `operand` at this edge |
| opCode | input | 3 | Operation select, codes 0..7 as in R3-R8 |
| operand | input | MAG_W+1 | Bit MAG_W is the sign, lower bits the magnitude |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| accSign | output | 1 | Accumulator sign |
| accGuard | output | 2 | Accumulator guard bits, [1] high, [0] low |
| accMag | output | MAG_W | Accumulator magnitude |
| overflow | output | 1 | Sticky overflow flag |
| done | output | 1 | Result written on the previous edge |

## Verification
The assertions assume the following about the inputs:

- `opCode`, `operand` and `ovfClear` are known, stable values whenever `start` is sampled high.
- `start` is never raised while reset is asserted.

The bench meets these conditions in three ways:

- It drives every input only at the falling edge.
- It keeps `start` low throughout reset.
- It draws codes from the eight defined values only.

Random operands mix tiny magnitudes, full-width values and values near all-ones. This mix makes carries into the guard bits, equal-magnitude cancellations and end-around carries occur often.

// File: rtl/acc_unit_pkg.sv
package acc_unit_pkg;

  typedef enum logic [2:0] {
    OP_LOAD       = 3'd0,
    OP_LOAD_NEG   = 3'd1,
    OP_LOAD_LOGIC = 3'd2,
    OP_ADD        = 3'd3,
    OP_SUB        = 3'd4,
    OP_ADD_MAG    = 3'd5,
    OP_SUB_MAG    = 3'd6,
    OP_ADD_LOGIC  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SGN_TRUE = 2'd0,
    SGN_FLIP = 2'd1,
    SGN_POS  = 2'd2,
    SGN_NEG  = 2'd3
  } sign_sel_e;

  typedef struct packed {
    logic      loadEn;
    logic      loadLogic;
    logic      arithEn;
    logic      logicAdd;
    sign_sel_e signSel;
  } strobe_t;

endpackage

// File: rtl/acc_unit_ctrl.sv
module acc_unit_ctrl
  import acc_unit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opCode,
  output strobe_t    strobe,
  output logic       done
);

  op_e opDec;
  assign opDec = op_e'(opCode);

  always_comb begin
    strobe = '0;
    if (start) begin
      unique case (opDec)
        OP_LOAD:       begin strobe.loadEn = 1'b1; strobe.signSel = SGN_TRUE; end
        OP_LOAD_NEG:   begin strobe.loadEn = 1'b1; strobe.signSel = SGN_FLIP; end
        OP_LOAD_LOGIC: begin strobe.loadEn = 1'b1; strobe.loadLogic = 1'b1; end
        OP_ADD:        begin strobe.arithEn = 1'b1; strobe.signSel = SGN_TRUE; end
        OP_SUB:        begin strobe.arithEn = 1'b1; strobe.signSel = SGN_FLIP; end
        OP_ADD_MAG:    begin strobe.arithEn = 1'b1; strobe.signSel = SGN_POS; end
        OP_SUB_MAG:    begin strobe.arithEn = 1'b1; strobe.signSel = SGN_NEG; end
        OP_ADD_LOGIC:  begin strobe.logicAdd = 1'b1; end
        default:       strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

endmodule

// File: rtl/acc_unit_dpath.sv
module acc_unit_dpath
  import acc_unit_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [MAG_W:0]   operand,
  input  logic             ovfClear,
  output logic             accSign,
  output logic [1:0]       accGuard,
  output logic [MAG_W-1:0] accMag,
  output logic             overflow
);

  localparam int FW  = MAG_W + 2;   // guard bits plus magnitude
  localparam int LW  = MAG_W + 1;   // low guard bit plus magnitude
  localparam int PAD = FW + 1 - MAG_W;

  logic             opSign;
  logic [MAG_W-1:0] opMag;
  logic             effSign;
  logic [FW-1:0]    accField;
  logic [FW:0]      likeSum;
  logic [MAG_W:0]   lowSum;
  logic [FW:0]      cmpSum;
  logic             topCarry;
  logic [FW-1:0]    unlikeField;
  logic [LW:0]      logSum;
  logic [LW-1:0]    logRes;
  logic             nSign;
  logic [FW-1:0]    nField;
  logic             setOvf;
  logic             likeSigns;

  assign opSign   = operand[MAG_W];
  assign opMag    = operand[MAG_W-1:0];
  assign accField = {accGuard, accMag};

  always_comb begin
    unique case (strobe.signSel)
      SGN_TRUE: effSign = opSign;
      SGN_FLIP: effSign = ~opSign;
      SGN_POS:  effSign = 1'b0;
      default:  effSign = 1'b1;
    endcase
  end

  assign likeSigns = (accSign == effSign);

  // like-sign path: true accumulator plus operand
  assign likeSum = {1'b0, accField} + {{PAD{1'b0}}, opMag};
  assign lowSum  = {1'b0, accMag} + {1'b0, opMag};

  // unlike-sign path: ones' complement of the whole field, then fix-up
  assign cmpSum      = {1'b0, ~accField} + {{PAD{1'b0}}, opMag};
  assign topCarry    = cmpSum[FW];
  assign unlikeField = topCarry ? (cmpSum[FW-1:0] + FW'(1)) : ~cmpSum[FW-1:0];

  // logical path with end-around carry
  assign logSum = {1'b0, accGuard[0], accMag} + {1'b0, opSign, opMag};
  assign logRes = logSum[LW-1:0] + LW'(logSum[LW]);

  always_comb begin
    nSign  = accSign;
    nField = accField;
    setOvf = 1'b0;
    if (strobe.loadEn) begin
      if (strobe.loadLogic) begin
        nSign  = 1'b0;
        nField = {1'b0, opSign, opMag};
      end else begin
        nSign  = effSign;
        nField = {2'b00, opMag};
      end
    end else if (strobe.arithEn) begin
      if (likeSigns) begin
        nField = likeSum[FW-1:0];
        setOvf = lowSum[MAG_W];
      end else begin
        nField = unlikeField;
        nSign  = topCarry ? ~accSign : accSign;
      end
    end else if (strobe.logicAdd) begin
      nField = {accGuard[1], logRes};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accSign  <= 1'b0;
      accGuard <= 2'b00;
      accMag   <= '0;
      overflow <= 1'b0;
    end else begin
      accSign            <= nSign;
      {accGuard, accMag} <= nField;
      overflow           <= (overflow & ~ovfClear) | setOvf;
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !ovfClear |=> overflow);

  // R9
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(strobe.arithEn));

endmodule

// File: rtl/acc_adder_unit.sv
module acc_adder_unit
  import acc_unit_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       opCode,
  input  logic [MAG_W:0]   operand,
  input  logic             ovfClear,
  output logic             accSign,
  output logic [1:0]       accGuard,
  output logic [MAG_W-1:0] accMag,
  output logic             overflow,
  output logic             done
);

  strobe_t strobe;

  acc_unit_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opCode (opCode),
    .strobe (strobe),
    .done   (done)
  );

  acc_unit_dpath #(.MAG_W(MAG_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .operand  (operand),
    .ovfClear (ovfClear),
    .accSign  (accSign),
    .accGuard (accGuard),
    .accMag   (accMag),
    .overflow (overflow)
  );

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(accSign) && $stable(accGuard) && $stable(accMag));

  // R3
  plain_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && (opCode == OP_LOAD) |=>
      accGuard == 2'b00 && accMag == $past(operand[MAG_W-1:0])
      && accSign == $past(operand[MAG_W]));

  // R4
  logic_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && (opCode == OP_LOAD_LOGIC) |=>
      !accSign && !accGuard[1] && accGuard[0] == $past(operand[MAG_W]));

  // R8
  logic_add_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && (opCode == OP_ADD_LOGIC) && !ovfClear |=>
      $stable(accSign) && $stable(overflow) && accGuard[1] == $past(accGuard[1]));

endmodule

// File: tb/acc_adder_unit_bench.sv
`timescale 1ns/1ps
module acc_adder_unit_bench;
  localparam int MW = 35;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    opCode = 3'd0;
  logic [MW:0]   operand = '0;
  logic          ovfClear = 1'b0;
  logic          accSign;
  logic [1:0]    accGuard;
  logic [MW-1:0] accMag;
  logic          overflow;
  logic          done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic          mS = 1'b0;
  logic [1:0]    mG = 2'b00;
  logic [MW-1:0] mM = '0;
  logic          mOvf = 1'b0;

  always #2 clk = ~clk;

  acc_adder_unit #(.MAG_W(MW)) u_acc_adder_unit (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .operand(operand),
    .ovfClear(ovfClear), .accSign(accSign), .accGuard(accGuard), .accMag(accMag),
    .overflow(overflow), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelOp(input logic [2:0] op, input logic [MW:0] opnd);
    logic          s;
    logic [63:0]   m, a, t;
    logic          es;
    s = opnd[MW];
    m = 64'(opnd[MW-1:0]);
    a = 64'({mG, mM});
    case (op)
      3'd0: begin mS = s;  mG = 2'b00;       mM = opnd[MW-1:0]; end
      3'd1: begin mS = ~s; mG = 2'b00;       mM = opnd[MW-1:0]; end
      3'd2: begin mS = 0;  mG = {1'b0, s};   mM = opnd[MW-1:0]; end
      3'd7: begin
        t = 64'({mG[0], mM}) + 64'({s, opnd[MW-1:0]});
        if (t[MW+1]) t = (t & ((64'd1 << (MW+1)) - 1)) + 1;
        mG[0] = t[MW];
        mM = t[MW-1:0];
      end
      default: begin
        es = (op == 3'd3) ? s : (op == 3'd4) ? ~s : (op == 3'd5) ? 1'b0 : 1'b1;
        if (es == mS) begin
          if (((64'(mM) + m) >> MW) != 0) mOvf = 1'b1;
          t = (a + m) & ((64'd1 << (MW+2)) - 1);
        end else if (m > a) begin
          t = m - a;
          mS = ~mS;
        end else begin
          t = a - m;
        end
        {mG, mM} = t[MW+1:0];
      end
    endcase
  endtask

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R3";
      3'd2:       return "R4";
      3'd7:       return "R8";
      default:    return "R5/R6/R7";
    endcase
  endfunction

  task automatic checkAcc(input string req);
    chk(req, 64'({accSign, accGuard, accMag}), 64'({mS, mG, mM}));
    chk("R9 overflow", 64'(overflow), 64'(mOvf));
  endtask

  task automatic doOp(input logic [2:0] op, input logic [MW:0] opnd, input logic clr);
    @(negedge clk);
    start = 1'b1; opCode = op; operand = opnd; ovfClear = clr;
    @(negedge clk);
    start = 1'b0; ovfClear = 1'b0;
    if (clr) mOvf = 1'b0;
    modelOp(op, opnd);
    chk("R2 done pulse", 64'(done), 64'd1);
    checkAcc(reqOf(op));
  endtask

  function automatic logic [MW:0] mk(input logic s, input longint v);
    return {s, v[MW-1:0]};
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] ones;
    ones = '1;
    void'($urandom(32'd20240611));

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 acc", 64'({accSign, accGuard, accMag}), 64'd0);
    chk("R1 overflow", 64'(overflow), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 done idle", 64'(done), 64'd0);

    // R6 unlike signs, accumulator smaller: -6 + 7 = +1
    doOp(3'd0, mk(1, 6), 0);
    doOp(3'd3, mk(0, 7), 0);
    chk("R6 sign flip", 64'(accSign), 64'd0);
    // R6 accumulator larger: -7 + 6 = -1
    doOp(3'd0, mk(1, 7), 0);
    doOp(3'd3, mk(0, 6), 0);
    chk("R6 sign kept", 64'({accSign, accMag}), 64'({1'b1, 35'd1}));
    // R6 equal magnitudes leave a negative zero
    doOp(3'd0, mk(1, 5), 0);
    doOp(3'd3, mk(0, 5), 0);
    chk("R6 negative zero", 64'({accSign, accGuard, accMag}), 64'({1'b1, 2'b00, 35'd0}));

    // R7 subtract and magnitude forms
    doOp(3'd0, mk(0, 3), 0);
    doOp(3'd4, mk(0, 5), 0);
    chk("R7 sub", 64'({accSign, accMag}), 64'({1'b1, 35'd2}));
    doOp(3'd0, mk(1, 4), 0);
    doOp(3'd5, mk(1, 10), 0);
    chk("R7 add magnitude", 64'({accSign, accMag}), 64'({1'b0, 35'd6}));
    doOp(3'd0, mk(0, 4), 0);
    doOp(3'd6, mk(0, 10), 0);
    chk("R7 sub magnitude", 64'({accSign, accMag}), 64'({1'b1, 35'd6}));
    doOp(3'd1, mk(0, 9), 0);
    chk("R3 negated load", 64'(accSign), 64'd1);

    // R5 overflow into guard bits
    doOp(3'd0, {1'b0, ones}, 0);
    doOp(3'd3, mk(0, 1), 0);
    chk("R5 overflow set", 64'({overflow, accGuard, accMag}), 64'({1'b1, 2'b01, 35'd0}));
    // R6 guard bits join the ones' complement
    doOp(3'd3, mk(1, 1), 0);
    chk("R6 guard borrow", 64'({accSign, accGuard, accMag}), 64'({1'b0, 2'b00, ones}));
    chk("R9 sticky", 64'(overflow), 64'd1);
    // R2 hold without start
    repeat (3) @(negedge clk);
    chk("R2 done idle", 64'(done), 64'd0);
    checkAcc("R2 hold");
    // R9 clear alone, then clear together with a new overflow
    @(negedge clk); ovfClear = 1'b1;
    @(negedge clk); ovfClear = 1'b0; mOvf = 1'b0;
    chk("R9 cleared", 64'(overflow), 64'd0);
    doOp(3'd3, {1'b0, ones}, 1);
    chk("R9 set wins", 64'(overflow), 64'd1);

    // R8 logical ops with high guard bit set
    doOp(3'd0, {1'b0, ones}, 0);
    doOp(3'd3, {1'b0, ones}, 0);
    doOp(3'd3, {1'b0, ones}, 0);
    doOp(3'd7, {1'b1, ones}, 0);
    chk("R8 high guard kept", 64'(accGuard[1]), 64'd1);
    doOp(3'd2, mk(1, 5), 0);
    chk("R4 logical load", 64'({accSign, accGuard, accMag}), 64'({1'b0, 2'b01, 35'd5}));
    doOp(3'd7, {1'b1, ones}, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r0, r1, r2;
      logic [MW-1:0] mg;
      r0 = $urandom(); r1 = $urandom(); r2 = $urandom();
      case (r0[1:0])
        2'd0:    mg = MW'(r1[3:0]);
        2'd1:    mg = ones - MW'(r1[3:0]);
        default: mg = {r2[MW-33:0], r1};
      endcase
      doOp(r0[6:4], {r0[8], mg}, (r0[15:12] == 4'd0));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule